// File: doc/BRIEF.md
# Configurable LUT Logic Slice

This block is a soft model of one programmable logic slice. Four 4-input lookup tables, arranged as two pairs, all see the same four operand bits. Inside each pair a first-level wide multiplexer chooses between the two table outputs. A second-level wide multiplexer then chooses between the two pairs. The first-level result is therefore any 5-input function, and the second-level result is any 6-input function of the operands and the two selects.

Two output paths carry these results. Path X carries the first-level result of the lower pair. Path Y carries the second-level result. Each path can either pass its value straight through or hold it in a storage element. A storage element works as an edge-triggered flip-flop or as a level-sensitive latch. Both storage elements share one clock enable and one set/reset line. Set/reset loads the configured initial value and can be made synchronous or asynchronous. A force line loads the inverse of that value.

All truth tables and storage options come from a 71-bit configuration word. The word is shifted in serially on its own clock. A load strobe then copies it into the active register in one step.

Top module: `lut_slice`

## Requirements
- R1: Configuration bit k of the active word (k = 0..63) is the truth table entry for address k, where address = {mux_sel_b, mux_sel_a, lut_in[3:0]}. With both selects 0, f5_out and f6_out equal bit lut_in of the word, so any 4-input function can be realised.
- R2: f5_out equals active bit {mux_sel_a, lut_in}, whatever the value of mux_sel_b. It is the 5-input function of the lower table pair.
- R3: f6_out equals active bit {mux_sel_b, mux_sel_a, lut_in}. It is a 6-input function that matches a 64-entry reference table.
- R4: A path whose keep bit is 0 is in bypass. Its output follows its combinational source with no clock edge (out_x follows f5_out, out_y follows f6_out).
- R5: A kept path in flip-flop mode (latch bit 0) changes only at a rising clk edge. It loads its source when ce is 1 and holds when ce is 0.
- R6: A kept path in latch mode (latch bit 1) is transparent while clk is 1 and ce is 1. It holds its value while clk is 0 or ce is 0.
- R7: sr loads the configured initial value. When the sync bit is 1 this happens at a rising clk edge. When the sync bit is 0 it happens at once, with no edge.
- R8: force_opp loads the inverse of the initial value. sr takes priority over force_opp, and force_opp takes priority over ce and data.
- R9: Configuration bits are shifted in on rising cfg_clk edges while cfg_load is 0, most significant bit first. A rising cfg_clk edge with cfg_load at 1 copies the whole word into the active register. Until that copy, shifting has no effect on any output. Word layout: bit 64 keep X, bit 65 latch X, bit 66 initial X, bits 67 to 69 the same three fields for Y, bit 70 sync set/reset.
- R10: After rst_n is low, every table holds zeros, both paths are in bypass, both storage elements are in flip-flop mode with initial value 0, and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage clock (also the latch gate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| lut_in | input | 4 | Operand bits shared by all tables |
| mux_sel_a | input | 1 | First-level wide multiplexer select |
| mux_sel_b | input | 1 | Second-level wide multiplexer select |
| ce | input | 1 | Shared clock enable |
| sr | input | 1 | Shared set/reset to the initial value |
| force_opp | input | 1 | Force to the inverse of the initial value |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_din | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy the shifted word into the active register |
| f5_out | output | 1 | 5-input function of the lower pair |
| f6_out | output | 1 | 6-input function |
| out_x | output | 1 | Path X output |
| out_y | output | 1 | Path Y output |

## Verification
Set/reset, force and clock enable can all be asserted in the same cycle. The bench raises all three together before one edge, then drops sr, then drops force_opp. Each time it checks that the winning control alone decides both paths, using different initial values on X and Y. The second overlap is the asynchronous set/reset arriving in the middle of a held cycle. Out_y is judged right after sr rises, before any clock edge, and again at the edges that follow.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  localparam int LUT_K       = 4;
  localparam int LUT_BITS    = 1 << LUT_K;
  localparam int NUM_LUT     = 4;
  localparam int TT_BITS     = NUM_LUT * LUT_BITS;
  localparam int NUM_STORE   = 2;
  localparam int STORE_FIELD = 3;
  localparam int CFG_W       = TT_BITS + NUM_STORE * STORE_FIELD + 1;

  typedef struct packed {
    logic init_val;
    logic latch_mode;
    logic keep;
  } store_cfg_t;

  function automatic logic lut_pick(input logic [LUT_BITS-1:0] tbl,
                                    input logic [LUT_K-1:0] idx);
    return tbl[idx];
  endfunction

  function automatic logic mux2(input logic s, input logic a0, input logic a1);
    return s ? a1 : a0;
  endfunction
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int W = 71
) (
  input  logic         cfg_clk,
  input  logic         rst_n,
  input  logic         cfg_din,
  input  logic         cfg_load,
  output logic [W-1:0] active
);
  logic [W-1:0] shreg;

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      active <= '0;
    end else if (cfg_load) begin
      active <= shreg;
    end else begin
      shreg <= {shreg[W-2:0], cfg_din};
    end
  end

  assert_shift_hidden_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_load |=> $stable(active));
  assert_load_copies_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_load |=> (active == $past(shreg)));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_slice_pkg::*;
(
  input  logic [LUT_BITS-1:0] tbl,
  input  logic [LUT_K-1:0]    idx,
  output logic                o
);
  always_comb o = lut_pick(tbl, idx);
endmodule

// File: rtl/slice_store.sv
module slice_store
  import lut_slice_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  store_cfg_t cfg,
  input  logic       sync_sr,
  input  logic       d,
  input  logic       ce,
  input  logic       sr,
  input  logic       force_opp,
  output logic       q
);
  logic ff_q;
  logic lat_q;
  logic async_clr;
  logic sr_hit;

  assign async_clr = sr & ~sync_sr;
  assign sr_hit    = sr & (~sync_sr | clk);

  always_ff @(posedge clk or negedge rst_n or posedge async_clr) begin
    if (!rst_n)         ff_q <= 1'b0;
    else if (async_clr) ff_q <= cfg.init_val;
    else if (sr)        ff_q <= cfg.init_val;
    else if (force_opp) ff_q <= ~cfg.init_val;
    else if (ce)        ff_q <= d;
  end

  always_latch begin
    if (!rst_n)                 lat_q = 1'b0;
    else if (sr_hit)            lat_q = cfg.init_val;
    else if (clk && force_opp)  lat_q = ~cfg.init_val;
    else if (clk && ce)         lat_q = d;
  end

  always_comb begin
    if (!cfg.keep)           q = d;
    else if (cfg.latch_mode) q = lat_q;
    else                     q = ff_q;
  end

  assert_sr_loads_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sr |=> (ff_q == $past(cfg.init_val)));
  assert_force_inverse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr && force_opp) |=> (ff_q == ~$past(cfg.init_val)));
  assert_ce_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr && !force_opp && ce) |=> (ff_q == $past(d)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr && !force_opp && !ce) |=> ((ff_q == $past(ff_q)) || sr));
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LUT_K-1:0]  lut_in,
  input  logic              mux_sel_a,
  input  logic              mux_sel_b,
  input  logic              ce,
  input  logic              sr,
  input  logic              force_opp,
  input  logic              cfg_clk,
  input  logic              cfg_din,
  input  logic              cfg_load,
  output logic              f5_out,
  output logic              f6_out,
  output logic              out_x,
  output logic              out_y
);
  logic [CFG_W-1:0]   cfg_word;
  logic [NUM_LUT-1:0] lut_o;
  logic [1:0]         f5_pair;
  logic [1:0]         path_d;
  logic [1:0]         path_q;

  lut_cfg_chain #(.W(CFG_W)) u_cfg (
    .cfg_clk (cfg_clk),
    .rst_n   (rst_n),
    .cfg_din (cfg_din),
    .cfg_load(cfg_load),
    .active  (cfg_word)
  );

  for (genvar i = 0; i < NUM_LUT; i++) begin : g_lut
    lut_cell u_lut (
      .tbl(cfg_word[i*LUT_BITS +: LUT_BITS]),
      .idx(lut_in),
      .o  (lut_o[i])
    );
  end

  for (genvar p = 0; p < 2; p++) begin : g_f5
    assign f5_pair[p] = mux2(mux_sel_a, lut_o[2*p], lut_o[2*p+1]);
  end

  assign f5_out = f5_pair[0];
  assign f6_out = mux2(mux_sel_b, f5_pair[0], f5_pair[1]);
  assign path_d = {f6_out, f5_out};

  for (genvar s = 0; s < NUM_STORE; s++) begin : g_store
    slice_store u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_word[TT_BITS + s*STORE_FIELD +: STORE_FIELD]),
      .sync_sr  (cfg_word[CFG_W-1]),
      .d        (path_d[s]),
      .ce       (ce),
      .sr       (sr),
      .force_opp(force_opp),
      .q        (path_q[s])
    );
  end

  assign out_x = path_q[0];
  assign out_y = path_q[1];

  always_comb begin
    if (rst_n && !cfg_word[TT_BITS] && !cfg_word[TT_BITS+STORE_FIELD])
      assert_bypass_follows_R4: assert ((out_x == f5_out) && (out_y == f6_out));
  end
endmodule

// File: tb/lut_slice_bench.sv
`timescale 1ns/100ps
module lut_slice_bench;
  localparam int CW = 71;
  localparam logic [63:0] TT = 64'h9C3E_61A7_05F8_D24B;
  localparam logic [5:0] VEC [0:11] = '{6'd0, 6'd1, 6'd15, 6'd16, 6'd31, 6'd32,
                                        6'd47, 6'd48, 6'd63, 6'd21, 6'd42, 6'd7};

  logic clk = 0, rst_n = 0;
  logic [3:0] lut_in = 0;
  logic mux_sel_a = 0, mux_sel_b = 0, ce = 0, sr = 0, force_opp = 0;
  logic cfg_clk = 0, cfg_din = 0, cfg_load = 0;
  logic f5_out, f6_out, out_x, out_y;
  int total = 0, bad = 0;
  bit done = 0;

  lut_slice u_lut_slice (.*);

  always #2.5 clk = ~clk;

  function automatic logic [CW-1:0] mk_cfg(logic [63:0] tt, logic kx, logic lx, logic ix,
                                           logic ky, logic ly, logic iy, logic sy);
    return {sy, iy, ly, ky, ix, lx, kx, tt};
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic shift_only(logic [CW-1:0] v);
    for (int i = CW-1; i >= 0; i--) begin
      cfg_din = v[i];
      #2 cfg_clk = 1;
      #2 cfg_clk = 0;
    end
  endtask

  task automatic do_load();
    cfg_load = 1;
    #2 cfg_clk = 1;
    #2 cfg_clk = 0;
    cfg_load = 0;
  endtask

  task automatic set_addr(logic [5:0] a);
    {mux_sel_b, mux_sel_a, lut_in} = a;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] a0, a1;
    a0 = 0; a1 = 0;
    for (int k = 0; k < 32; k++) begin
      if (TT[k] == 1'b0) a0 = 6'(k);
      if (TT[k] == 1'b1) a1 = 6'(k);
    end
    // R10: reset state
    set_addr(6'd63);
    #7 rst_n = 1;
    #1;
    chk("R10 f5", f5_out, 1'b0); chk("R10 f6", f6_out, 1'b0);
    chk("R10 x", out_x, 1'b0);   chk("R10 y", out_y, 1'b0);
    // R9: shifted word stays hidden until load
    shift_only(mk_cfg(TT, 0, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < 64; k++) begin
      set_addr(6'(k)); #0.5;
      chk("R9 hidden", f6_out, 1'b0);
    end
    do_load();
    // R1 R2 R3 R4: table walk then exhaustive
    foreach (VEC[i]) begin
      set_addr(VEC[i]); #0.5;
      chk("R3 vec f6", f6_out, TT[VEC[i]]);
      chk("R2 vec f5", f5_out, TT[VEC[i][4:0]]);
    end
    for (int k = 0; k < 64; k++) begin
      set_addr(6'(k)); #0.5;
      if (k < 16) chk("R1 lut", f6_out, TT[k]);
      chk("R3 f6", f6_out, TT[k]);
      chk("R2 f5", f5_out, TT[k[4:0]]);
      chk("R4 x", out_x, TT[k[4:0]]);
      chk("R4 y", out_y, TT[k]);
    end
    // R5: flip-flop mode, sync set/reset, init x=0 y=1
    shift_only(mk_cfg(TT, 1, 0, 0, 1, 0, 1, 1));
    do_load();
    @(negedge clk); set_addr(a1); ce = 1;
    @(posedge clk); #1;
    chk("R5 load x", out_x, 1'b1); chk("R5 load y", out_y, TT[a1]);
    @(negedge clk); set_addr(a0); ce = 0; #0.5;
    chk("R5 no edge", out_x, 1'b1);
    @(posedge clk); #1;
    chk("R5 hold ce0", out_x, 1'b1);
    @(negedge clk); ce = 1;
    @(posedge clk); #1;
    chk("R5 reload", out_x, 1'b0); chk("R5 reload y", out_y, TT[a0]);
    // R8 R7: all three together, sync
    @(negedge clk); set_addr(a1); sr = 1; force_opp = 1; ce = 1; #1;
    chk("R7 sync waits edge", out_x, 1'b0);
    chk("R7 sync waits edge y", out_y, TT[a0]);
    @(posedge clk); #1;
    chk("R8 sr wins x", out_x, 1'b0); chk("R8 sr wins y", out_y, 1'b1);
    @(negedge clk); sr = 0;
    @(posedge clk); #1;
    chk("R8 force x", out_x, 1'b1); chk("R8 force y", out_y, 1'b0);
    @(negedge clk); force_opp = 0; set_addr(a0);
    @(posedge clk); #1;
    chk("R8 ce after force x", out_x, 1'b0); chk("R8 ce after force y", out_y, TT[a0]);
    // R7: asynchronous set/reset on y (init 1), x bypass
    @(negedge clk); ce = 0;
    shift_only(mk_cfg(TT, 0, 0, 0, 1, 0, 1, 0));
    do_load();
    @(negedge clk); force_opp = 1;
    @(posedge clk); #1;
    chk("R8 force y async cfg", out_y, 1'b0);
    @(negedge clk); force_opp = 0;
    @(posedge clk);
    @(negedge clk); #1 sr = 1; #0.5;
    chk("R7 async no edge", out_y, 1'b1);
    @(posedge clk); #1;
    chk("R7 async held", out_y, 1'b1);
    @(negedge clk); sr = 0;
    @(posedge clk); #1;
    chk("R7 async after", out_y, 1'b1);
    // R6: latch mode on x
    @(negedge clk);
    shift_only(mk_cfg(TT, 1, 1, 0, 0, 0, 0, 0));
    do_load();
    @(negedge clk); set_addr(a0); ce = 1;
    @(posedge clk); #1;
    chk("R6 open", out_x, 1'b0);
    @(negedge clk); #0.5 set_addr(a1); #1;
    chk("R6 closed hold", out_x, 1'b0);
    @(posedge clk); #1;
    chk("R6 transparent", out_x, 1'b1);
    @(negedge clk); ce = 0;
    @(posedge clk); #0.5 set_addr(a0); #0.5;
    chk("R6 ce0 hold", out_x, 1'b1);
    @(negedge clk); ce = 1;
    @(posedge clk); #0.5 set_addr(a1); #0.5;
    chk("R6 follows", out_x, 1'b1);
    #0.5 set_addr(a0); #0.5;
    chk("R6 follows low", out_x, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule